// File: doc/BRIEF.md
# Opcode Fetch and Refresh Bus Sequencer

This block produces the bus control waveforms of an 8-bit processor. Its main job is the opcode fetch: the program counter goes out on the address bus, the memory is strobed, the opcode is captured, and the second half of the fetch becomes a refresh slot for dynamic memory. During that slot the interrupt-page register sits on the high address byte and a refresh counter sits on the low byte. The refresh counter advances once at the end of every fetch. Simpler cycle kinds are also supported: memory read, memory write, port read and port write.

The block runs on a clock at twice the machine-state rate, so each machine state (T-state) is two ticks. The first tick of a state is its first half and the second tick is its second half. A requester presents a cycle kind with `start` while `busy` is low. The block latches the kind and the halt flag, steps through the states, and pulses `done` on the final tick. While halted, a fetch still runs the full bus sequence. In that case the opcode is forced to zero (a no-operation), and the program counter owner gets no increment pulse. Both internal registers can be loaded directly.

Top module: `fetchseq_top`

## Requirements
- R1: Kind code 0 is an opcode fetch of four T-states. The address bus carries `pc` during T1 and T2. `m1N` is low for all of T1 and T2. `mreqN` and `rdN` go low from the second half of T1 until the end of T2.
- R2: In a fetch, `rdData` is captured at the edge that ends T2 and appears on `opcode`. `pcInc` is high for exactly one tick, the second half of T2, so that the same edge advances the program counter.
- R3: In T3 and T4 of a fetch, the address bus carries {interrupt-page register, refresh register} and `rfshN` is low for both states. `mreqN` is low from the second half of T3 through the first half of T4. `rdN` and `m1N` stay high whenever `rfshN` is low.
- R4: At the end of each fetch, the low 7 bits of the refresh register increment with wrap, and bit 7 keeps its value: 0x7F becomes 0x00 and 0xFF becomes 0x80.
- R5: A direct load of the refresh register (`rWrEn`) on the same tick as the end-of-fetch increment takes priority: the loaded value is kept.
- R6: A fetch started with `halt` high keeps every strobe waveform of R1 and R3 and still increments the refresh register. It drives `opcode` to 0x00 whatever `rdData` is, and never raises `pcInc`.
- R7: Kind 1 (memory read) and kind 2 (memory write) each last three T-states with `reqAddr` on the bus. `mreqN` is low from the second half of T1 through the first half of T3. For a read, `rdN` follows `mreqN` and `rdData` is captured to `readData` at the end of the first half of T3. For a write, `wrN` is low from the second half of T2 through the first half of T3, and `dataOe` is high for the whole cycle. Neither kind changes the refresh register.
- R8: Kind 3 (port read) and kind 4 (port write) assert `iorqN` together with `rdN` or `wrN` from the start of T2 through the first half of T3, and never assert `mreqN`. These cycles then idle for three further T-states, six in total.
- R9: Reset clears the interrupt-page and refresh registers, `opcode` and `readData`. It leaves every strobe inactive (high) and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per T-state |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a cycle when idle |
| kind | input | 3 | Cycle kind code (0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write) |
| halt | input | 1 | Halted state, latched at start |
| pc | input | 16 | Program counter |
| reqAddr | input | 16 | Address for memory and port cycles |
| wrData | input | 8 | Data for write cycles |
| rdData | input | 8 | Data returned by memory or port |
| iWrEn | input | 1 | Load interrupt-page register |
| iWrData | input | 8 | Value for interrupt-page register |
| rWrEn | input | 1 | Load refresh register |
| rWrData | input | 8 | Value for refresh register |
| addrBus | output | 16 | Address bus |
| dataOut | output | 8 | Write data |
| dataOe | output | 1 | Write data enable |
| m1N | output | 1 | Opcode fetch strobe, active low |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| iorqN | output | 1 | Port request, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| opcode | output | 8 | Captured opcode |
| readData | output | 8 | Captured memory or port read data |
| pcInc | output | 1 | Program counter advance enable |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last tick of a cycle |
| regIOut | output | 8 | Interrupt-page register value |
| regROut | output | 8 | Refresh register value |

## Verification
Two updates of the refresh register can land on the same tick: the automatic increment at the end of a fetch, and a direct load. The bench raises `rWrEn` exactly on the final tick of a fetch and expects the loaded value afterwards, not that value plus one. The bench also compares every tick of every cycle kind against a T-state table built from the requirements. Halted fetches are checked with nonzero memory data, so that a forced zero opcode can be told apart from a captured one.

// File: rtl/fetchseq_pkg.sv
package fetchseq_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } cycKind_e;

  typedef enum logic [1:0] {
    A_PC   = 2'd0,
    A_REQ  = 2'd1,
    A_RFSH = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     m1;
    logic     mreq;
    logic     rd;
    logic     wr;
    logic     iorq;
    logic     rfsh;
    logic     capture;
    logic     forceNop;
    logic     pcInc;
    logic     rInc;
    logic     dataOe;
    logic     done;
    addrSel_e addrSel;
  } strobes_t;
endpackage

// File: rtl/fetchseq_ctrl.sv
module fetchseq_ctrl
  import fetchseq_pkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3,
  parameter int IO_T    = 3,
  parameter int IO_TAIL = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] kind,
  input  logic       halt,
  output logic       busy,
  output strobes_t   st
);
  localparam int MAX_T = FETCH_T + MEM_T + IO_T + IO_TAIL;
  localparam int T_W   = $clog2(MAX_T + 1);
  localparam logic [T_W-1:0] T1 = T_W'(0);
  localparam logic [T_W-1:0] T2 = T_W'(1);
  localparam logic [T_W-1:0] T3 = T_W'(2);
  localparam logic [T_W-1:0] T4 = T_W'(3);

  cycKind_e       kindQ;
  logic           haltQ;
  logic [T_W-1:0] tIdx;
  logic           ph;
  logic [T_W-1:0] lastT;
  logic           lastTick;
  logic           isT1, isT2, isT3, isT4;

  always_comb begin
    case (kindQ)
      K_FETCH:        lastT = T_W'(FETCH_T - 1);
      K_IORD, K_IOWR: lastT = T_W'(IO_T + IO_TAIL - 1);
      default:        lastT = T_W'(MEM_T - 1);
    endcase
  end

  assign lastTick = busy && ph && (tIdx == lastT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      kindQ <= K_FETCH;
      haltQ <= 1'b0;
      tIdx  <= T1;
      ph    <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        kindQ <= cycKind_e'(kind);
        haltQ <= halt;
        tIdx  <= T1;
        ph    <= 1'b0;
      end
    end else if (lastTick) begin
      busy <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) tIdx <= tIdx + T_W'(1);
    end
  end

  assign isT1 = (tIdx == T1);
  assign isT2 = (tIdx == T2);
  assign isT3 = (tIdx == T3);
  assign isT4 = (tIdx == T4);

  always_comb begin
    st         = '0;
    st.addrSel = A_PC;
    if (busy) begin
      st.done = lastTick;
      case (kindQ)
        K_FETCH: begin
          st.m1       = isT1 | isT2;
          st.rd       = (isT1 & ph) | isT2;
          st.rfsh     = isT3 | isT4;
          st.mreq     = st.rd | (isT3 & ph) | (isT4 & ~ph);
          st.addrSel  = st.rfsh ? A_RFSH : A_PC;
          st.capture  = isT2 & ph;
          st.forceNop = haltQ;
          st.pcInc    = isT2 & ph & ~haltQ;
          st.rInc     = lastTick;
        end
        K_MRD, K_MWR: begin
          st.addrSel = A_REQ;
          st.mreq    = (isT1 & ph) | isT2 | (isT3 & ~ph);
          if (kindQ == K_MRD) begin
            st.rd      = st.mreq;
            st.capture = isT3 & ~ph;
          end else begin
            st.wr     = (isT2 & ph) | (isT3 & ~ph);
            st.dataOe = 1'b1;
          end
        end
        K_IORD, K_IOWR: begin
          st.addrSel = A_REQ;
          st.iorq    = isT2 | (isT3 & ~ph);
          if (kindQ == K_IORD) begin
            st.rd      = st.iorq;
            st.capture = isT3 & ~ph;
          end else begin
            st.wr     = st.iorq;
            st.dataOe = 1'b1;
          end
        end
        default: st.addrSel = A_REQ;
      endcase
    end
  end
endmodule

// File: rtl/fetchseq_dp.sv
module fetchseq_dp
  import fetchseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int R_CNT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              iWrEn,
  input  logic [DATA_W-1:0] iWrData,
  input  logic              rWrEn,
  input  logic [DATA_W-1:0] rWrData,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] opcode,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] regI,
  output logic [DATA_W-1:0] regR
);
  localparam int REF_W = 2 * DATA_W;

  logic [REF_W-1:0] refAddr;
  assign refAddr = {regI, regR};

  always_comb begin
    case (st.addrSel)
      A_REQ:   addrBus = reqAddr;
      A_RFSH:  addrBus = ADDR_W'(refAddr);
      default: addrBus = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regI <= '0;
      regR <= '0;
    end else begin
      if (iWrEn) regI <= iWrData;
      if (rWrEn) regR <= rWrData;
      else if (st.rInc)
        regR <= {regR[DATA_W-1:R_CNT_W], regR[R_CNT_W-1:0] + R_CNT_W'(1)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcode   <= '0;
      readData <= '0;
    end else if (st.capture) begin
      if (st.m1) opcode <= st.forceNop ? '0 : rdData;
      else       readData <= rdData;
    end
  end
endmodule

// File: rtl/fetchseq_top.sv
module fetchseq_top
  import fetchseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int R_CNT_W = 7,
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3,
  parameter int IO_T    = 3,
  parameter int IO_TAIL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        kind,
  input  logic              halt,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdData,
  input  logic              iWrEn,
  input  logic [DATA_W-1:0] iWrData,
  input  logic              rWrEn,
  input  logic [DATA_W-1:0] rWrData,
  output logic [ADDR_W-1:0] addrBus,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic              iorqN,
  output logic              rfshN,
  output logic [DATA_W-1:0] opcode,
  output logic [DATA_W-1:0] readData,
  output logic              pcInc,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] regIOut,
  output logic [DATA_W-1:0] regROut
);
  strobes_t st;

  fetchseq_ctrl #(
    .FETCH_T(FETCH_T), .MEM_T(MEM_T), .IO_T(IO_T), .IO_TAIL(IO_TAIL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .kind(kind), .halt(halt),
    .busy(busy), .st(st)
  );

  fetchseq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .R_CNT_W(R_CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .pc(pc), .reqAddr(reqAddr),
    .rdData(rdData), .iWrEn(iWrEn), .iWrData(iWrData), .rWrEn(rWrEn),
    .rWrData(rWrData), .addrBus(addrBus), .opcode(opcode),
    .readData(readData), .regI(regIOut), .regR(regROut)
  );

  assign m1N     = ~st.m1;
  assign mreqN   = ~st.mreq;
  assign rdN     = ~st.rd;
  assign wrN     = ~st.wr;
  assign iorqN   = ~st.iorq;
  assign rfshN   = ~st.rfsh;
  assign pcInc   = st.pcInc;
  assign done    = st.done;
  assign dataOe  = st.dataOe;
  assign dataOut = wrData;
endmodule

// File: rtl/fetchseq_chk.sv
module fetchseq_chk #(
  parameter int DATA_W  = 8,
  parameter int R_CNT_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              m1N,
  input logic              mreqN,
  input logic              rdN,
  input logic              wrN,
  input logic              iorqN,
  input logic              rfshN,
  input logic              pcInc,
  input logic              done,
  input logic              forceNop,
  input logic              rWrEn,
  input logic [DATA_W-1:0] rWrData,
  input logic [DATA_W-1:0] regROut
);
  // R1: while the fetch strobe and memory request are both low, the read strobe is low
  a_r1_fetch_reads: assert property (@(posedge clk) disable iff (!rstN)
    (!m1N && !mreqN) |-> !rdN);

  a_r2_pcinc_in_fetch: assert property (@(posedge clk) disable iff (!rstN)
    pcInc |-> (!m1N && !rdN && !mreqN));

  a_r3_rfsh_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> (rdN && wrN && m1N && iorqN));

  a_r4_r_step: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rfshN && !rWrEn) |=>
      (regROut[R_CNT_W-1:0] == $past(regROut[R_CNT_W-1:0]) + R_CNT_W'(1)) &&
      (regROut[DATA_W-1:R_CNT_W] == $past(regROut[DATA_W-1:R_CNT_W])));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    rWrEn |=> (regROut == $past(rWrData)));

  a_r6_halt_no_pcinc: assert property (@(posedge clk) disable iff (!rstN)
    forceNop |-> !pcInc);

  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r8_io_no_mreq: assert property (@(posedge clk) disable iff (!rstN)
    !iorqN |-> mreqN);
endmodule

bind fetchseq_top fetchseq_chk #(.DATA_W(DATA_W), .R_CNT_W(R_CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
  .iorqN(iorqN), .rfshN(rfshN), .pcInc(pcInc), .done(done),
  .forceNop(st.forceNop), .rWrEn(rWrEn), .rWrData(rWrData), .regROut(regROut)
);

// File: tb/fetchseq_top_tb.sv
module fetchseq_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        halt = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic [15:0] reqAddr = 16'h0000;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData = 8'h00;
  logic        iWrEn = 1'b0;
  logic [7:0]  iWrData = 8'h00;
  logic        rWrEn = 1'b0;
  logic [7:0]  rWrData = 8'h00;
  logic [15:0] addrBus;
  logic [7:0]  dataOut, opcode, readData, regIOut, regROut;
  logic        dataOe, m1N, mreqN, rdN, wrN, iorqN, rfshN, pcInc, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fetchseq_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .kind(kind), .halt(halt),
    .pc(pc), .reqAddr(reqAddr), .wrData(wrData), .rdData(rdData),
    .iWrEn(iWrEn), .iWrData(iWrData), .rWrEn(rWrEn), .rWrData(rWrData),
    .addrBus(addrBus), .dataOut(dataOut), .dataOe(dataOe), .m1N(m1N),
    .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .iorqN(iorqN), .rfshN(rfshN),
    .opcode(opcode), .readData(readData), .pcInc(pcInc), .busy(busy),
    .done(done), .regIOut(regIOut), .regROut(regROut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected active strobes {m1,mreq,rd,wr,iorq,rfsh} per tick, from the requirements
  function automatic logic [5:0] expStrobes(input int k, input int t);
    logic [5:0] e = 6'b0;
    case (k)
      0: begin // R1, R3
        if (t <= 3) e[5] = 1'b1;
        if (t >= 1 && t <= 3) begin e[4] = 1'b1; e[3] = 1'b1; end
        if (t >= 4) e[0] = 1'b1;
        if (t == 5 || t == 6) e[4] = 1'b1;
      end
      1, 2: begin // R7
        if (t >= 1 && t <= 4) e[4] = 1'b1;
        if (k == 1 && t >= 1 && t <= 4) e[3] = 1'b1;
        if (k == 2 && (t == 3 || t == 4)) e[2] = 1'b1;
      end
      default: begin // R8
        if (t >= 2 && t <= 4) begin
          e[1] = 1'b1;
          if (k == 3) e[3] = 1'b1; else e[2] = 1'b1;
        end
      end
    endcase
    return e;
  endfunction

  function automatic int cycTicks(input int k);
    if (k == 0) return 8;
    if (k <= 2) return 6;
    return 12;
  endfunction

  // Runs one cycle; loadR on the final tick drives rWrEn with rVal
  task automatic runCycle(input int k, input bit h, input bit loadR, input logic [7:0] rVal,
                          output int pcIncCnt, output int badTicks);
    logic [5:0] act;
    pcIncCnt = 0;
    badTicks = 0;
    @(negedge clk);
    kind = 3'(k); halt = h; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < cycTicks(k); t++) begin
      act = {~m1N, ~mreqN, ~rdN, ~wrN, ~iorqN, ~rfshN};
      if (act !== expStrobes(k, t)) begin
        badTicks++;
        $display("FAIL strobes kind=%0d tick=%0d actual=%b expected=%b",
                 k, t, act, expStrobes(k, t));
      end
      if (pcInc) pcIncCnt++;
      if (k == 0 && t <= 3 && addrBus !== pc) badTicks++;
      if (k == 0 && t >= 4 && addrBus !== {regIOut, regROut}) badTicks++;
      if (k != 0 && addrBus !== reqAddr) badTicks++;
      if (k == 2 || k == 4) begin
        if (!dataOe || dataOut !== wrData) badTicks++;
      end
      if (t == cycTicks(k) - 1) begin
        if (!done) badTicks++;
        if (loadR) begin rWrEn = 1'b1; rWrData = rVal; end
      end
      @(negedge clk);
      rWrEn = 1'b0;
    end
  endtask

  task automatic loadRegs(input logic [7:0] iv, input logic [7:0] rv);
    @(negedge clk);
    iWrEn = 1'b1; iWrData = iv; rWrEn = 1'b1; rWrData = rv;
    @(negedge clk);
    iWrEn = 1'b0; rWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R9 registers", {16'h0, regIOut, regROut}, 32'h0);
    check("R9 captures", {16'h0, opcode, readData}, 32'h0);
    check("R9 strobes idle", {26'h0, m1N, mreqN, rdN, wrN, iorqN, rfshN}, 32'h3f);
    check("R9 busy low", {31'h0, busy}, 32'h0);
  endtask

  task automatic testFetch();
    int n, bad;
    loadRegs(8'h3c, 8'h11);
    pc = 16'h1234; rdData = 8'hA5;
    runCycle(0, 1'b0, 1'b0, 8'h00, n, bad);
    check("R1 R3 fetch waveform", bad, 0);
    check("R2 pcInc one tick", n, 1);
    check("R2 opcode", {24'h0, opcode}, {24'h0, 8'hA5});
    check("R4 refresh step", {24'h0, regROut}, 32'h12);
    check("R9 busy after", {31'h0, busy}, 32'h0);
  endtask

  task automatic testWrap();
    int n, bad;
    loadRegs(8'h00, 8'h7f);
    runCycle(0, 1'b0, 1'b0, 8'h00, n, bad);
    check("R4 wrap 7F waveform", bad, 0);
    check("R4 wrap 7F->00", {24'h0, regROut}, 32'h00);
    loadRegs(8'h00, 8'hff);
    runCycle(0, 1'b0, 1'b0, 8'h00, n, bad);
    check("R4 wrap FF->80", {24'h0, regROut}, 32'h80);
  endtask

  task automatic testLoadWins();
    int n, bad;
    loadRegs(8'h00, 8'h20);
    runCycle(0, 1'b0, 1'b1, 8'h55, n, bad);
    check("R5 load over increment", {24'h0, regROut}, 32'h55);
  endtask

  task automatic testHalt();
    int n, bad;
    loadRegs(8'h80, 8'h05);
    pc = 16'h4000; rdData = 8'hC3;
    runCycle(0, 1'b1, 1'b0, 8'h00, n, bad);
    check("R6 halt waveform", bad, 0);
    check("R6 halt no pcInc", n, 0);
    check("R6 halt opcode NOP", {24'h0, opcode}, 32'h0);
    check("R6 halt refresh step", {24'h0, regROut}, 32'h06);
  endtask

  task automatic testMem();
    int n, bad;
    logic [7:0] rBefore;
    rBefore = regROut;
    reqAddr = 16'h8001; rdData = 8'h5A;
    runCycle(1, 1'b0, 1'b0, 8'h00, n, bad);
    check("R7 mem read waveform", bad, 0);
    check("R7 read data", {24'h0, readData}, 32'h5A);
    reqAddr = 16'h9002; wrData = 8'h77;
    runCycle(2, 1'b0, 1'b0, 8'h00, n, bad);
    check("R7 mem write waveform", bad, 0);
    check("R7 no pcInc", n, 0);
    check("R7 refresh unchanged", {24'h0, regROut}, {24'h0, rBefore});
  endtask

  task automatic testIo();
    int n, bad;
    reqAddr = 16'h00fe; rdData = 8'h3e;
    runCycle(3, 1'b0, 1'b0, 8'h00, n, bad);
    check("R8 port read waveform", bad, 0);
    check("R8 port read data", {24'h0, readData}, 32'h3e);
    reqAddr = 16'h01ff; wrData = 8'hc4;
    runCycle(4, 1'b0, 1'b0, 8'h00, n, bad);
    check("R8 port write waveform", bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFetch();
    testWrap();
    testLoadWins();
    testHalt();
    testMem();
    testIo();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule